// File: doc/BRIEF.md
# TDM Slot Autobuffer Engine

This block links a multichannel time-division serial port to a six-word circular buffer held in local flops. Each frame holds 32 slots of 16 bits. Slots 0 to 2 carry outgoing words and slots 3 to 5 carry incoming words; every other slot is ignored. A transmit slot fetches its word from the buffer when the slot begins. A receive slot stores the finished word into the buffer when the slot ends.

One circular pointer serves both directions. This is safe because every transmit slot comes before every receive slot, and the two kinds of transfer are always at least one whole slot apart. The buffer holds, in pointer order, the left output, the right output, the control word, the status word, the left input and the right input. Outgoing words pass through a one-deep holding stage. As a result, the control word fetched at the end of one frame's transmit run is sent in slot 0 of the next frame. The interrupt comes only from the receive side, once per frame, when the pointer wraps after the last receive slot. A host reads and writes the buffer through a simple word port.

The serial bit clock reaches the block as a one-cycle enable on the system clock. Frame sync is sampled on that enable.

Top module: `tdm_autobuf_engine`

## Requirements
- R1: After reset, `sdout`, `frame_irq` and `irq_flag` are 0 and every buffer word reads 0.
- R2: Frame sync is sampled on a bit-clock enable. Slot 0 bit 15 is on the line for the bit period that starts at the next enable. Words are sent MSB first, 16 bits per slot. A frame holds 32 slots, after which the port waits for the next frame sync.
- R3: The transmit order is as follows. Slot 1 sends buffer word 0 and slot 2 sends buffer word 1. Slot 0 sends buffer word 2 as it stood when slot 2 of the previous frame began. Slot 0 sends 0 in the first frame after reset or after the port is disabled.
- R4: The words received in slots 3, 4 and 5 (MSB first) are stored in buffer words 3, 4 and 5, at the enable that ends each slot.
- R5: In slots 3 to 31, `sdout` is 0. `sdin` in slots 0 to 2 and 6 to 31 changes no buffer word.
- R6: A single pointer addresses both transmit fetches and receive stores. It advances by one per transfer, modulo 6, and a fetch and a store never fall in the same cycle.
- R7: `frame_irq` is a one-cycle pulse. It is high in the clock cycle right after the enable that ends slot 5, exactly once per frame. Transmit transfers raise no pulse.
- R8: `irq_flag` goes to 1 with each pulse and holds until `irq_clr`. A new pulse in the same cycle as `irq_clr` wins.
- R9: While `port_en` is 0, the pointer, the holding stage and the shifters are cleared, no transfer takes place, and `sdout` is 0 from the next cycle on.
- R10: A host write with `host_we` stores `host_wdata` at `host_addr`, and `host_rdata` shows the word at `host_addr` in the same cycle. If an engine store hits the same word in the same cycle, the engine store wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_en | input | 1 | Port enable; low clears the pointer and the datapath |
| bclk_en | input | 1 | One-cycle strobe per serial bit clock |
| fsync | input | 1 | Frame sync, sampled on `bclk_en` |
| sdin | input | 1 | Serial receive data |
| sdout | output | 1 | Serial transmit data |
| frame_irq | output | 1 | One-cycle frame interrupt pulse |
| irq_flag | output | 1 | Sticky copy of the interrupt |
| irq_clr | input | 1 | Clears `irq_flag` |
| host_we | input | 1 | Host buffer write strobe |
| host_addr | input | 3 | Host buffer word address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data |

## Verification
On every cycle, the assertions check the shared pointer: it steps once per transfer with wrap at 6, stays put otherwise, and sees no fetch and store together. They also check the single-cycle shape and the cause of the interrupt, the behaviour of the sticky flag, and the clearing done by a port disable. Only the bench scenarios can show the serial side. These cover the one-frame delay of the control word through the holding stage, MSB-first alignment to frame sync, the mapping of receive slots to buffer words, and the fact that unused slots leave the buffer untouched.

// File: rtl/tdm_autobuf_pkg.sv
package tdm_autobuf_pkg;

    localparam int DEF_WORD_W      = 16;
    localparam int DEF_FRAME_SLOTS = 32;
    localparam int DEF_TX_BASE     = 0;
    localparam int DEF_TX_SLOTS    = 3;
    localparam int DEF_RX_BASE     = 3;
    localparam int DEF_RX_SLOTS    = 3;

    // True when slot index lies in [base, base+count)
    function automatic logic slot_in(input int slot, input int base, input int count);
        return (slot >= base) && (slot < base + count);
    endfunction

endpackage

// File: rtl/tdm_slot_timer.sv
module tdm_slot_timer
    import tdm_autobuf_pkg::*;
#(
    parameter int WORD_W      = DEF_WORD_W,
    parameter int FRAME_SLOTS = DEF_FRAME_SLOTS,
    parameter int TX_BASE     = DEF_TX_BASE,
    parameter int TX_SLOTS    = DEF_TX_SLOTS,
    parameter int RX_BASE     = DEF_RX_BASE,
    parameter int RX_SLOTS    = DEF_RX_SLOTS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic port_en,
    input  logic bclk_en,
    input  logic fsync,
    output logic tx_load,
    output logic rx_store,
    output logic bit_adv,
    output logic tx_live
);

    localparam int SLOT_W = $clog2(FRAME_SLOTS);
    localparam int BIT_W  = $clog2(WORD_W);
    localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(WORD_W - 1);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_SLOTS - 1);

    typedef struct packed {
        logic              run;
        logic [SLOT_W-1:0] slot;
        logic [BIT_W-1:0]  bitn;
    } tstate_t;

    tstate_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        tx_load  = 1'b0;
        rx_store = 1'b0;
        bit_adv  = 1'b0;
        if (!port_en) begin
            st_d = '0;
        end else if (bclk_en) begin
            bit_adv  = st_q.run;
            rx_store = st_q.run && (st_q.bitn == LAST_BIT)
                       && slot_in(int'(st_q.slot), RX_BASE, RX_SLOTS);
            if (fsync) begin
                st_d.run  = 1'b1;
                st_d.slot = '0;
                st_d.bitn = '0;
            end else if (st_q.run) begin
                if (st_q.bitn == LAST_BIT) begin
                    st_d.bitn = '0;
                    if (st_q.slot == LAST_SLOT) begin
                        st_d.run  = 1'b0;
                        st_d.slot = '0;
                    end else begin
                        st_d.slot = st_q.slot + SLOT_W'(1);
                    end
                end else begin
                    st_d.bitn = st_q.bitn + BIT_W'(1);
                end
            end
            tx_load = st_d.run && (st_d.bitn == '0)
                      && (fsync || (st_q.bitn == LAST_BIT))
                      && slot_in(int'(st_d.slot), TX_BASE, TX_SLOTS);
        end
    end

    assign tx_live = st_q.run && slot_in(int'(st_q.slot), TX_BASE, TX_SLOTS);

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/tdm_word_serdes.sv
module tdm_word_serdes
    import tdm_autobuf_pkg::*;
#(
    parameter int WORD_W = DEF_WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_en,
    input  logic              bit_adv,
    input  logic              tx_load,
    input  logic              tx_live,
    input  logic              sdin,
    input  logic [WORD_W-1:0] fetch_word,
    output logic              sdout,
    output logic [WORD_W-1:0] rx_word
);

    typedef struct packed {
        logic [WORD_W-1:0] hold;   // one-deep transmit holding stage
        logic [WORD_W-1:0] txsh;   // transmit shifter, MSB on the line
        logic [WORD_W-2:0] rxsh;   // receive shifter, last bit comes from sdin
    } sstate_t;

    sstate_t sd_d, sd_q;

    always_comb begin
        sd_d = sd_q;
        if (!port_en) begin
            sd_d = '0;
        end else begin
            if (tx_load) begin
                sd_d.txsh = sd_q.hold;
                sd_d.hold = fetch_word;
            end else if (bit_adv) begin
                sd_d.txsh = {sd_q.txsh[WORD_W-2:0], 1'b0};
            end
            if (bit_adv) begin
                sd_d.rxsh = {sd_q.rxsh[WORD_W-3:0], sdin};
            end
        end
    end

    assign rx_word = {sd_q.rxsh, sdin};
    assign sdout   = tx_live & sd_q.txsh[WORD_W-1];

    always_ff @(posedge clk) begin
        if (!rst_n) sd_q <= '0;
        else        sd_q <= sd_d;
    end

endmodule

// File: rtl/tdm_slot_buffer.sv
module tdm_slot_buffer
    import tdm_autobuf_pkg::*;
#(
    parameter int WORD_W = DEF_WORD_W,
    parameter int DEPTH  = DEF_TX_SLOTS + DEF_RX_SLOTS,
    parameter int AW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eng_we,
    input  logic [AW-1:0]     eng_addr,
    input  logic [WORD_W-1:0] eng_wdata,
    output logic [WORD_W-1:0] eng_rdata,
    input  logic              host_we,
    input  logic [AW-1:0]     host_addr,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] host_rdata
);

    logic [WORD_W-1:0] mem_d [DEPTH];
    logic [WORD_W-1:0] mem_q [DEPTH];

    always_comb begin
        for (int w = 0; w < DEPTH; w++) begin
            mem_d[w] = mem_q[w];
            if (eng_we && (eng_addr == AW'(w)))        mem_d[w] = eng_wdata;
            else if (host_we && (host_addr == AW'(w))) mem_d[w] = host_wdata;
        end
    end

    always_comb begin
        eng_rdata  = '0;
        host_rdata = '0;
        for (int w = 0; w < DEPTH; w++) begin
            if (eng_addr == AW'(w))  eng_rdata  = mem_q[w];
            if (host_addr == AW'(w)) host_rdata = mem_q[w];
        end
    end

    always_ff @(posedge clk) begin
        for (int w = 0; w < DEPTH; w++) begin
            if (!rst_n) mem_q[w] <= '0;
            else        mem_q[w] <= mem_d[w];
        end
    end

endmodule

// File: rtl/tdm_autobuf_engine.sv
module tdm_autobuf_engine
    import tdm_autobuf_pkg::*;
#(
    parameter int WORD_W      = DEF_WORD_W,
    parameter int FRAME_SLOTS = DEF_FRAME_SLOTS,
    parameter int TX_BASE     = DEF_TX_BASE,
    parameter int TX_SLOTS    = DEF_TX_SLOTS,
    parameter int RX_BASE     = DEF_RX_BASE,
    parameter int RX_SLOTS    = DEF_RX_SLOTS
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    port_en,
    input  logic                                    bclk_en,
    input  logic                                    fsync,
    input  logic                                    sdin,
    output logic                                    sdout,
    output logic                                    frame_irq,
    output logic                                    irq_flag,
    input  logic                                    irq_clr,
    input  logic                                    host_we,
    input  logic [$clog2(TX_SLOTS+RX_SLOTS)-1:0]    host_addr,
    input  logic [WORD_W-1:0]                       host_wdata,
    output logic [WORD_W-1:0]                       host_rdata
);

    localparam int DEPTH = TX_SLOTS + RX_SLOTS;
    localparam int AW    = $clog2(DEPTH);
    localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] ptr;
        logic          irq;
        logic          flag;
    } estate_t;

    estate_t es_d, es_q;

    logic              tx_load, rx_store, bit_adv, tx_live;
    logic [WORD_W-1:0] fetch_word, rx_word;
    logic [AW-1:0]     ptr_q;

    assign ptr_q = es_q.ptr;

    tdm_slot_timer #(
        .WORD_W(WORD_W), .FRAME_SLOTS(FRAME_SLOTS),
        .TX_BASE(TX_BASE), .TX_SLOTS(TX_SLOTS),
        .RX_BASE(RX_BASE), .RX_SLOTS(RX_SLOTS)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .bclk_en(bclk_en),
        .fsync(fsync), .tx_load(tx_load), .rx_store(rx_store),
        .bit_adv(bit_adv), .tx_live(tx_live)
    );

    tdm_word_serdes #(.WORD_W(WORD_W)) u_serdes (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .bit_adv(bit_adv),
        .tx_load(tx_load), .tx_live(tx_live), .sdin(sdin),
        .fetch_word(fetch_word), .sdout(sdout), .rx_word(rx_word)
    );

    tdm_slot_buffer #(.WORD_W(WORD_W), .DEPTH(DEPTH), .AW(AW)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .eng_we(rx_store), .eng_addr(es_q.ptr), .eng_wdata(rx_word),
        .eng_rdata(fetch_word),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata)
    );

    // Shared pointer; the receive store at the last word closes the frame
    always_comb begin
        es_d     = es_q;
        es_d.irq = 1'b0;
        if (!port_en) begin
            es_d.ptr = '0;
        end else if (tx_load || rx_store) begin
            es_d.ptr = (es_q.ptr == LAST_PTR) ? '0 : es_q.ptr + AW'(1);
            es_d.irq = rx_store && (es_q.ptr == LAST_PTR);
        end
        if (irq_clr)  es_d.flag = 1'b0;
        if (es_d.irq) es_d.flag = 1'b1;
    end

    assign frame_irq = es_q.irq;
    assign irq_flag  = es_q.flag;

    always_ff @(posedge clk) begin
        if (!rst_n) es_q <= '0;
        else        es_q <= es_d;
    end

endmodule

// File: rtl/tdm_autobuf_chk.sv
module tdm_autobuf_chk #(
    parameter int DEPTH = 6,
    parameter int PTR_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             port_en,
    input logic             irq_clr,
    input logic             frame_irq,
    input logic             irq_flag,
    input logic             sdout,
    input logic [PTR_W-1:0] ptr_q,
    input logic             tx_load,
    input logic             rx_store
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    a_r6_single_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_load && rx_store));

    a_r6_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (port_en && (tx_load || rx_store)) |=>
        (!port_en || ptr_q == (($past(ptr_q) == LAST) ? '0 : $past(ptr_q) + PTR_W'(1))));

    a_r6_ptr_still: assert property (@(posedge clk) disable iff (!rst_n)
        (port_en && !tx_load && !rx_store) |=> (!port_en || $stable(ptr_q)));

    a_r9_ptr_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |=> (ptr_q == '0));

    a_r9_line_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |=> !sdout);

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        frame_irq |=> !frame_irq);

    a_r7_wrap_cause: assert property (@(posedge clk) disable iff (!rst_n)
        frame_irq |-> ($past(rx_store) && $past(ptr_q) == LAST));

    a_r8_flag_on: assert property (@(posedge clk) disable iff (!rst_n)
        frame_irq |-> irq_flag);

    a_r8_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !irq_clr) |=> irq_flag);

    a_r8_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clr |=> (irq_flag == frame_irq));

endmodule

bind tdm_autobuf_engine tdm_autobuf_chk u_chk (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .irq_clr(irq_clr),
    .frame_irq(frame_irq), .irq_flag(irq_flag), .sdout(sdout),
    .ptr_q(ptr_q), .tx_load(tx_load), .rx_store(rx_store)
);

// File: tb/sim_tdm_autobuf_engine.sv
module sim_tdm_autobuf_engine;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n, port_en, bclk_en, fsync, sdin, sdout;
    logic        frame_irq, irq_flag, irq_clr, host_we;
    logic [2:0]  host_addr;
    logic [15:0] host_wdata, host_rdata;

    tdm_autobuf_engine u0 (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .bclk_en(bclk_en),
        .fsync(fsync), .sdin(sdin), .sdout(sdout), .frame_irq(frame_irq),
        .irq_flag(irq_flag), .irq_clr(irq_clr), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // per frame: out0, out1, ctrl, rx slot3, rx slot4, rx slot5
    localparam logic [15:0] VEC [4][6] = '{
        '{16'h1234, 16'h5678, 16'h9ABC, 16'hDEF0, 16'h0F0F, 16'hF0F0},
        '{16'h8001, 16'h7FFE, 16'hC000, 16'h0001, 16'h8000, 16'hFFFF},
        '{16'hA5A5, 16'h5A5A, 16'h0000, 16'h3C3C, 16'hC3C3, 16'h0000},
        '{16'hFFFF, 16'h0000, 16'h8600, 16'h1111, 16'h2222, 16'h4444}
    };

    logic [15:0] got_tx [3];
    int stray, irq_hits, irq_at;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input logic fs, input logic din, output logic dout, output logic iq);
        @(negedge clk);
        dout    = sdout;
        bclk_en = 1'b1;
        fsync   = fs;
        sdin    = din;
        @(negedge clk);
        bclk_en = 1'b0;
        fsync   = 1'b0;
        iq      = frame_irq;
    endtask

    task automatic hwrite(input logic [2:0] a, input logic [15:0] v);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = v;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic hread(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk);
        host_addr = a;
        #1 v = host_rdata;
    endtask

    task automatic run_frame(input logic [15:0] r3, input logic [15:0] r4,
                             input logic [15:0] r5, input int n_ticks);
        logic d, iq;
        tick(1'b1, 1'b0, d, iq);
        stray    = d ? 1 : 0;
        irq_hits = iq ? 1 : 0;
        irq_at   = -1;
        for (int i = 0; i < n_ticks; i++) begin
            int s, b;
            logic din;
            s = i / 16;
            b = i % 16;
            din = 1'b1;
            if (s == 3) din = r3[15-b];
            if (s == 4) din = r4[15-b];
            if (s == 5) din = r5[15-b];
            tick(1'b0, din, d, iq);
            if (s < 3) got_tx[s][15-b] = d;
            else if (d) stray++;
            if (iq) begin irq_hits++; irq_at = i; end
        end
    endtask

    task automatic clear_flag();
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
    endtask

    initial begin
        logic [15:0] v;
        rst_n = 1'b0; port_en = 1'b1; bclk_en = 1'b0; fsync = 1'b0; sdin = 1'b0;
        irq_clr = 1'b0; host_we = 1'b0; host_addr = '0; host_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        chk("R1 sdout", sdout, 0);
        chk("R1 frame_irq", frame_irq, 0);
        chk("R1 irq_flag", irq_flag, 0);
        for (int a = 0; a < 6; a++) begin
            hread(3'(a), v);
            chk("R1 buffer word", v, 0);
        end

        // R10 host write then read back
        hwrite(3'd3, 16'hBEEF);
        hread(3'd3, v);
        chk("R10 host readback", v, 16'hBEEF);

        // vector table walk
        for (int f = 0; f < 4; f++) begin
            for (int a = 0; a < 3; a++) hwrite(3'(a), VEC[f][a]);
            run_frame(VEC[f][3], VEC[f][4], VEC[f][5], 512);
            chk("R3 slot0 delayed ctrl", got_tx[0], (f == 0) ? 16'h0 : VEC[f-1][2]);
            chk("R2 R3 slot1 word0", got_tx[1], VEC[f][0]);
            chk("R3 slot2 word1", got_tx[2], VEC[f][1]);
            chk("R5 sdout quiet", stray, 0);
            chk("R7 one pulse", irq_hits, 1);
            chk("R7 pulse after slot5", irq_at, 95);
            for (int a = 3; a < 6; a++) begin
                hread(3'(a), v);
                chk("R4 R6 rx store", v, VEC[f][a]);
            end
            for (int a = 0; a < 3; a++) begin
                hread(3'(a), v);
                chk("R5 words untouched", v, VEC[f][a]);
            end
            chk("R8 flag set", irq_flag, 1);
            @(negedge clk);
            chk("R8 flag held", irq_flag, 1);
            clear_flag();
            chk("R8 flag cleared", irq_flag, 0);
        end

        // R9 disable mid-frame restarts pointer and clears holding stage
        hwrite(3'd0, 16'h1111);
        hwrite(3'd1, 16'h2222);
        hwrite(3'd2, 16'h3333);
        run_frame(16'h0, 16'h0, 16'h0, 20);
        @(negedge clk); port_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R9 sdout low while disabled", sdout, 0);
        port_en = 1'b1;
        run_frame(16'hAAAA, 16'hBBBB, 16'hCCCC, 512);
        chk("R9 slot0 hold cleared", got_tx[0], 16'h0);
        chk("R9 R6 slot1 from word0", got_tx[1], 16'h1111);
        chk("R9 slot2 from word1", got_tx[2], 16'h2222);
        hread(3'd3, v); chk("R9 rx word3", v, 16'hAAAA);
        hread(3'd5, v); chk("R9 rx word5", v, 16'hCCCC);
        chk("R7 pulse after restart", irq_hits, 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule